// File: doc/BRIEF.md
# Block Copy Engine with In-Memory Command Descriptor

This engine copies a run of words from one memory region to another without the processor doing the copy. Software places a four-word descriptor in memory and gives the engine only the descriptor's address, along with a one-cycle start pulse. The engine then takes the shared bus and reads the descriptor itself. The descriptor words are, at increasing addresses, the source address, the destination address, a mode word and the word count. After that the engine moves the data one word at a time.

For every memory access the engine first raises a bus request and waits for the grant, so it takes the bus away from the processor. For each word it reads one location, writes that value to the other location, and then drops its request for at least one cycle so the processor can win the bus back. When the whole block has been moved, it raises one interrupt flag. That flag stays set until software clears it.

Top module: `blkmv_dma`

## Requirements
- R1: A `start` pulse sampled while the engine is idle raises `busy` in the next cycle. `busy` stays high until the cycle after the last access of the job.
- R2: `mem_re` and `mem_we` are only ever high in a cycle in which both `bus_req` and `bus_gnt` are high.
- R3: The descriptor is fetched with four reads at `cmd_addr`, `cmd_addr+1`, `cmd_addr+2` and `cmd_addr+3`, issued in that order on consecutive cycles. Their meaning is, in order: source, destination, mode, count.
- R4: A word move is a read, followed in the very next cycle by a write of the returned `mem_rdata`. After each move both addresses advance by one, and exactly `count` words are moved.
- R5: When bit 0 of the mode word is 0, data is read at the source and written at the destination. When it is 1, the roles swap: data is read at the destination address and written at the source address.
- R6: A count of 0 ends the job right after the descriptor fetch, with no data access, and the interrupt is still raised.
- R7: After every data write, `bus_req` is low in the following cycle.
- R8: A `start` pulse while `busy` is high is ignored and does not affect the job in progress.
- R9: `irq` rises in the cycle after the job's final step and stays high until a cycle in which `irq_clr` is sampled high. If completion and `irq_clr` fall in the same cycle, the completion wins and `irq` is set.
- R10: While `rst_n` is low (synchronous reset), `busy`, `irq`, `bus_req`, `mem_re` and `mem_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| cmd_addr | input | AW | Word address of the four-word descriptor |
| irq_clr | input | 1 | Write-1 clear of the completion flag |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant, held while the request stays high |
| mem_addr | output | AW | Memory word address |
| mem_re | output | 1 | Read strobe; data appears on `mem_rdata` one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data from the synchronous memory |
| busy | output | 1 | A job is in progress |
| irq | output | 1 | Sticky completion flag |

## Verification
The engine setting its completion flag and software clearing that flag can land in the same cycle. The bench provokes this by holding `irq_clr` high for the whole of the swapped-direction job. A per-cycle model then expects `irq` to read 1 for exactly one cycle after the final write and to read 0 after that. A second collision is a new `start` arriving in the middle of a job. The model ignores it, and the destination contents that the bench checks afterwards show that the job was not redirected.

// File: rtl/blkmv_pkg.sv
// Shared types for the block copy engine.
// Assumes a four-word descriptor laid out as source, destination, mode, count.
package blkmv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for start
        ST_CREQ,    // requesting bus for descriptor fetch
        ST_CFETCH,  // streaming descriptor reads
        ST_XREQ,    // requesting bus for one data word
        ST_XWR,     // writing the word just read
        ST_XGAP     // bus released between words
    } blk_state_t;

    localparam int CMD_WORDS = 4;
    localparam int FLD_SRC   = 0;
    localparam int FLD_DST   = 1;
    localparam int FLD_MODE  = 2;
    localparam int FLD_CNT   = 3;
endpackage

// File: rtl/blkmv_seq.sv
// Job sequencer: walks the descriptor fetch and the per-word copy loop.
// Assumes bus_gnt, once given, stays high while bus_req stays high.
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          bus_gnt,
    input  logic          rd_zero,
    input  logic          last_word,
    output blk_state_t    state,
    output logic [KW-1:0] fidx,
    output logic          done_evt
);
    localparam logic [KW-1:0] FIDX_END = KW'(CMD_WORDS);

    // State and descriptor-index register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fidx  <= '0;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_CREQ;
                ST_CREQ:   if (bus_gnt) begin
                               state <= ST_CFETCH;
                               fidx  <= KW'(1);
                           end
                ST_CFETCH: if (fidx == FIDX_END) state <= rd_zero ? ST_IDLE : ST_XREQ;
                           else fidx <= fidx + KW'(1);
                ST_XREQ:   if (bus_gnt) state <= ST_XWR;
                ST_XWR:    state <= last_word ? ST_IDLE : ST_XGAP;
                ST_XGAP:   state <= ST_XREQ;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Completion strobe: empty job after fetch, or last word written.
    always_comb begin
        done_evt = ((state == ST_CFETCH) && (fidx == FIDX_END) && rd_zero)
                || ((state == ST_XWR) && last_word);
    end
endmodule

// File: rtl/blkmv_path.sv
// Address and count datapath plus bus/memory strobe decode.
// Assumes synchronous memory: read data is valid the cycle after mem_re.
module blkmv_path
    import blkmv_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  blk_state_t    state,
    input  logic [KW-1:0] fidx,
    input  logic          start,
    input  logic [AW-1:0] cmd_addr,
    input  logic          bus_gnt,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          last_word,
    output logic          rd_zero
);
    localparam logic [KW-1:0] FIDX_END = KW'(CMD_WORDS);

    logic [AW-1:0] base_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic          swap_q;
    logic [DW-1:0] cnt_q;
    logic          fetching;

    assign fetching = (state == ST_CFETCH) && (fidx != FIDX_END);

    // Latch descriptor fields and step pointers and count per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            swap_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (state == ST_IDLE && start) base_q <= cmd_addr;
            if (state == ST_CFETCH) begin
                if (fidx == KW'(FLD_SRC + 1))  src_q  <= AW'(mem_rdata);
                if (fidx == KW'(FLD_DST + 1))  dst_q  <= AW'(mem_rdata);
                if (fidx == KW'(FLD_MODE + 1)) swap_q <= mem_rdata[0];
                if (fidx == KW'(FLD_CNT + 1))  cnt_q  <= mem_rdata;
            end
            if (state == ST_XWR) begin
                src_q <= src_q + AW'(1);
                dst_q <= dst_q + AW'(1);
                cnt_q <= cnt_q - DW'(1);
            end
        end
    end

    // Strobe, address and data decode for the current state.
    always_comb begin
        bus_req   = (state == ST_CREQ) || fetching || (state == ST_XREQ) || (state == ST_XWR);
        mem_re    = ((state == ST_CREQ) && bus_gnt) || fetching || ((state == ST_XREQ) && bus_gnt);
        mem_we    = (state == ST_XWR);
        mem_wdata = (state == ST_XWR) ? mem_rdata : '0;
        case (state)
            ST_CREQ:   mem_addr = base_q;
            ST_CFETCH: mem_addr = base_q + AW'(fidx);
            ST_XREQ:   mem_addr = swap_q ? dst_q : src_q;
            ST_XWR:    mem_addr = swap_q ? src_q : dst_q;
            default:   mem_addr = '0;
        endcase
    end

    assign last_word = (cnt_q == DW'(1));
    assign rd_zero   = (mem_rdata == '0);
endmodule

// File: rtl/blkmv_irq.sv
// Sticky completion flag with write-1 clear; a set in the same cycle wins.
module blkmv_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end
endmodule

// File: rtl/blkmv_dma.sv
// Top of the block copy engine: fetches a descriptor, copies words one
// read/write pair at a time under request/grant, flags completion once.
// Assumes the arbiter holds bus_gnt while bus_req stays high.
module blkmv_dma
    import blkmv_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cmd_addr,
    input  logic          irq_clr,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          irq
);
    localparam int KW = $clog2(CMD_WORDS + 1);

    blk_state_t    state;
    logic [KW-1:0] fidx;
    logic          done_evt;
    logic          last_word;
    logic          rd_zero;

    blkmv_seq #(.KW(KW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_gnt(bus_gnt),
        .rd_zero(rd_zero), .last_word(last_word),
        .state(state), .fidx(fidx), .done_evt(done_evt)
    );

    blkmv_path #(.AW(AW), .DW(DW), .KW(KW)) u_path (
        .clk(clk), .rst_n(rst_n), .state(state), .fidx(fidx),
        .start(start), .cmd_addr(cmd_addr), .bus_gnt(bus_gnt),
        .mem_rdata(mem_rdata), .bus_req(bus_req), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .last_word(last_word), .rd_zero(rd_zero)
    );

    blkmv_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_evt(done_evt), .clr(irq_clr), .flag(irq)
    );

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/blkmv_dma_chk.sv
// Port-level protocol checker for blkmv_dma, attached by bind.
module blkmv_dma_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_clr,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          mem_re,
    input logic          mem_we,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          irq
);
    // R2: no memory access without owning the bus
    assert_access_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re || mem_we) |-> (bus_req && bus_gnt));

    // R4: every write directly follows a read
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    // R7: bus released in the cycle after a data write
    assert_release_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !bus_req);

    // R1: idle engine is silent on the bus
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_req || mem_re || mem_we));

    // R9: flag holds until cleared
    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R9: flag only rises at the end of a job
    assert_irq_from_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy));
endmodule

bind blkmv_dma blkmv_dma_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .busy(busy), .irq(irq)
);

// File: tb/tb_blkmv_dma.sv
module tb_blkmv_dma;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          irq_clr = 1'b0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    int zero_run_writes = 0;
    logic in_zero_run = 1'b0;

    logic [15:0] mem [0:255];
    logic [31:0] seed = 32'h1234_5678;
    int          gdly = 0;

    // reference model state
    int          m_phase = 0;
    int          m_k = 0;
    logic [15:0] m_base = '0, m_src = '0, m_dst = '0, m_cnt = '0;
    logic        m_swap = 1'b0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    blkmv_dma #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
        .irq_clr(irq_clr), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'hA500 ^ 16'(a * 37);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Arbiter: grants after a pseudo-random wait, holds while requested.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            gdly    <= 0;
        end else if (!bus_req) begin
            bus_gnt <= 1'b0;
        end else if (!bus_gnt) begin
            if (gdly == 0) begin
                bus_gnt <= 1'b1;
                seed    <= seed * 32'd1103515245 + 32'd12345;
                gdly    <= int'(seed[18:17]);
            end else begin
                gdly <= gdly - 1;
            end
        end
    end

    // Memory and reference model step.
    always @(posedge clk) begin
        logic done;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
            mem[8'h10] <= 16'h0040; mem[8'h11] <= 16'h0080; mem[8'h12] <= 16'h0000; mem[8'h13] <= 16'd5;
            mem[8'h20] <= 16'h00A0; mem[8'h21] <= 16'h00C0; mem[8'h22] <= 16'h0001; mem[8'h23] <= 16'd3;
            mem[8'h30] <= 16'h0060; mem[8'h31] <= 16'h00E0; mem[8'h32] <= 16'h0000; mem[8'h33] <= 16'd0;
            mem[8'h38] <= 16'h0050; mem[8'h39] <= 16'h0090; mem[8'h3A] <= 16'h0000; mem[8'h3B] <= 16'd1;
            mem_rdata <= '0;
            m_phase = 0; m_k = 0; m_irq = 1'b0;
        end else begin
            done = 1'b0;
            case (m_phase)
                0: if (start) begin m_base = cmd_addr; m_phase = 1; end
                1: if (bus_gnt) begin m_k = 1; m_phase = 2; end
                2: begin
                    if (m_k == 1) m_src = mem_rdata;
                    if (m_k == 2) m_dst = mem_rdata;
                    if (m_k == 3) m_swap = mem_rdata[0];
                    if (m_k == 4) begin
                        m_cnt = mem_rdata;
                        if (mem_rdata == 0) begin done = 1'b1; m_phase = 0; end
                        else m_phase = 3;
                    end else m_k++;
                end
                3: if (bus_gnt) m_phase = 4;
                4: begin
                    m_src++; m_dst++;
                    if (m_cnt == 1) begin done = 1'b1; m_phase = 0; end
                    else m_phase = 5;
                    m_cnt--;
                end
                default: m_phase = 3;
            endcase
            if (done) m_irq = 1'b1;
            else if (irq_clr) m_irq = 1'b0;
            if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                if (in_zero_run) zero_run_writes++;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        logic e_req, e_re, e_we;
        logic [15:0] e_addr;
        if (!rst_n) begin
            chk("R10 busy in reset", 32'(busy), 0);
            chk("R10 irq in reset", 32'(irq), 0);
            chk("R10 bus_req in reset", 32'(bus_req), 0);
            chk("R10 strobes in reset", 32'({mem_re, mem_we}), 0);
        end else begin
            e_req = 1'b0; e_re = 1'b0; e_we = 1'b0; e_addr = '0;
            case (m_phase)
                1: begin e_req = 1'b1; e_re = bus_gnt; e_addr = m_base; end
                2: if (m_k < 4) begin e_req = 1'b1; e_re = 1'b1; e_addr = m_base + 16'(m_k); end
                3: begin e_req = 1'b1; e_re = bus_gnt; e_addr = m_swap ? m_dst : m_src; end
                4: begin e_req = 1'b1; e_we = 1'b1; e_addr = m_swap ? m_src : m_dst; end
                default: ;
            endcase
            chk("R1 busy", 32'(busy), 32'(m_phase != 0));
            chk((m_phase == 5) ? "R7 bus_req gap" : "R2 bus_req", 32'(bus_req), 32'(e_req));
            chk((m_phase <= 2) ? "R3 mem_re" : "R4 mem_re", 32'(mem_re), 32'(e_re));
            chk("R4 mem_we", 32'(mem_we), 32'(e_we));
            if (e_re || e_we)
                chk((m_phase <= 2) ? "R3 mem_addr" : (m_swap ? "R5 mem_addr" : "R4 mem_addr"),
                    32'(mem_addr), 32'(e_addr));
            if (e_we) chk("R4 mem_wdata", 32'(mem_wdata), 32'(mem_rdata));
            chk("R9 irq", 32'(irq), 32'(m_irq));
        end
    end

    task automatic launch(input logic [15:0] a);
        @(negedge clk);
        start = 1'b1; cmd_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int t = 0;
        while (busy && t < 2000) begin @(negedge clk); t++; end
        if (busy) begin
            n_cmp++; n_bad++;
            $display("FAIL %s watchdog: actual=busy expected=idle", tag);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R3/R4/R8: forward copy of 5 words, with a stray start mid-job
        launch(16'h0010);
        repeat (10) @(negedge clk);
        start = 1'b1; cmd_addr = 16'h0030;
        @(negedge clk);
        start = 1'b0;
        wait_idle("R1");
        chk("R9 irq after job", 32'(irq), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk("R9 irq cleared", 32'(irq), 0);

        // R5/R9: swapped direction, clear held high across completion
        irq_clr = 1'b1;
        launch(16'h0020);
        wait_idle("R5");
        irq_clr = 1'b0;
        chk("R9 clear after collision", 32'(irq), 0);

        // R6: empty job
        in_zero_run = 1'b1;
        launch(16'h0030);
        wait_idle("R6");
        in_zero_run = 1'b0;
        chk("R6 no writes", 32'(zero_run_writes), 0);
        chk("R6 irq raised", 32'(irq), 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;

        // R4: single-word job
        launch(16'h0038);
        wait_idle("R4");

        for (int i = 0; i < 5; i++) chk("R4 dest data", 32'(mem[8'h80 + i]), 32'(pat(8'h40 + i)));
        chk("R4 count bound", 32'(mem[8'h85]), 32'(pat(8'h85)));
        chk("R8 stray start ignored", 32'(mem[8'hE0]), 32'(pat(8'hE0)));
        for (int i = 0; i < 3; i++) chk("R5 swapped data", 32'(mem[8'hA0 + i]), 32'(pat(8'hC0 + i)));
        chk("R5 read side untouched", 32'(mem[8'hC0]), 32'(pat(8'hC0)));
        chk("R6 dest untouched", 32'(mem[8'hE0]), 32'(pat(8'hE0)));
        chk("R4 single word", 32'(mem[8'h90]), 32'(pat(8'h50)));
        chk("R4 single bound", 32'(mem[8'h91]), 32'(pat(8'h91)));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule